// File: doc/BRIEF.md
# Saturating Scaled Radix-2 Butterfly

This block is the arithmetic core of an in-place FFT or IFFT engine. Each cycle it can accept two complex two's-complement operands, A and B, and one complex twiddle factor, Wt. Three cycles later it returns two complex results, Y0 and Y1, at the same word width as the data memory. A build parameter selects the butterfly form:

- **Time-decimated form:** B is rotated by the twiddle first, and the rotated value is then added to and subtracted from A.
- **Frequency-decimated form:** A + B and A − B are formed first, and only the difference is rotated.

Inside the datapath nothing is dropped. Sums and differences grow by one sign bit, and products keep the combined width of both factors. Only the last stage scales the values down by a right shift and then clamps them to the word range, so a result never wraps around.

A sticky flag records that some result has been clamped since the last start-of-frame pulse. Address sequencing, twiddle generation and memories sit outside this block.

Top module: `bfly_core`

## Requirements
In these requirements:
- W is the data width and TW is the twiddle width.
- The twiddle is signed with F = TW−1 fraction bits, so 2^F stands for +1.0.
- S is the SHIFT parameter.
- floor() is rounding toward minus infinity.
- sat() clamps a value to the range −2^(W−1) … 2^(W−1)−1.
- Lanes are real and imaginary parts.

- R1: While rst_n is low, valid_out, sat_flag and all four result lanes are 0.
- R2: valid_out equals valid_in delayed by exactly 3 clock cycles. Results leave in the order their operands entered, with no gaps added or removed.
- R3: With USE_DIF = 0, Y0 = sat(floor((A·2^F + B·Wt) / 2^(F+S))) and Y1 = sat(floor((A·2^F − B·Wt) / 2^(F+S))), computed per lane with complex B·Wt.
- R4: With USE_DIF = 1, Y0 = sat(floor((A+B) / 2^S)) and Y1 = sat(floor(((A−B)·Wt) / 2^(F+S))).
- R5: Full-scale operands, including all lanes at −2^(W−1), give exactly the results of R3/R4. No intermediate sum or product wraps.
- R6: A lane whose shifted value is above 2^(W−1)−1 is output as 2^(W−1)−1.
- R7: A lane whose shifted value is below −2^(W−1) is output as −2^(W−1).
- R8: sat_flag goes high in the same cycle that valid_out presents a clamped lane. It then stays high until it is cleared.
- R9: sof high at a clock edge clears sat_flag at that edge. If a clamped result is registered at that same edge, the flag is set instead.
- R10: Operands presented with valid_in low produce no valid_out and never set sat_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Start-of-frame pulse that clears the clamp flag |
| valid_in | input | 1 | Operands and twiddle are valid this cycle |
| a_re | input | W | Operand A, real part |
| a_im | input | W | Operand A, imaginary part |
| b_re | input | W | Operand B, real part |
| b_im | input | W | Operand B, imaginary part |
| w_re | input | TW | Twiddle, real part (F fraction bits) |
| w_im | input | TW | Twiddle, imaginary part (F fraction bits) |
| valid_out | output | 1 | Results are valid this cycle |
| y0_re | output | W | Result Y0, real part |
| y0_im | output | W | Result Y0, imaginary part |
| y1_re | output | W | Result Y1, real part |
| y1_im | output | W | Result Y1, imaginary part |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
Unity, +j and −1 twiddles are applied to both butterfly forms. They separate a swapped operand, a swapped lane and a wrong sign on the imaginary cross terms of the complex product.

Full-scale and most-negative operands show whether the extra growth bit is really present. Diagonal twiddles drive one lane past the positive bound and then past the negative bound, and so tell a clamp from a wrap.

A long pseudo-random stream with gaps and start-of-frame pulses at random points checks latency, ordering and the set-over-clear rule of the flag. Idle cycles that carry out-of-range operands show that invalid data is ignored.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Clamp indicator: either nothing clamped since the last frame start,
    // or at least one lane clamped.
    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_HELD  = 1'b1
    } flag_state_e;

endpackage

// File: rtl/bfly_addsub.sv
// Sum and difference with one bit of growth: both operands are
// sign-extended before the add, so neither result can wrap.
module bfly_addsub #(
    parameter int IW = 12
) (
    input  logic signed [IW-1:0] x,
    input  logic signed [IW-1:0] y,
    output logic signed [IW:0]   sum,
    output logic signed [IW:0]   dif
);
    assign sum = (IW+1)'(x) + (IW+1)'(y);
    assign dif = (IW+1)'(x) - (IW+1)'(y);
endmodule

// File: rtl/bfly_cmul.sv
// Complex multiply at full precision. Each partial product is AW+BW bits
// wide; combining two partial products adds one more bit.
module bfly_cmul #(
    parameter int AW = 12,
    parameter int BW = 12
) (
    input  logic signed [AW-1:0]  xr,
    input  logic signed [AW-1:0]  xi,
    input  logic signed [BW-1:0]  wr,
    input  logic signed [BW-1:0]  wi,
    output logic signed [AW+BW:0] pr,
    output logic signed [AW+BW:0] pi
);
    localparam int PW = AW + BW;

    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;

    assign m_rr = xr * wr;
    assign m_ii = xi * wi;
    assign m_ri = xr * wi;
    assign m_ir = xi * wr;

    assign pr = (PW+1)'(m_rr) - (PW+1)'(m_ii);
    assign pi = (PW+1)'(m_ri) + (PW+1)'(m_ir);
endmodule

// File: rtl/bfly_satshift.sv
// Arithmetic right shift by SH bits, then clamp to an OW-bit signed range.
module bfly_satshift #(
    parameter int IW = 26,
    parameter int OW = 12,
    parameter int SH = 12
) (
    input  logic signed [IW-1:0] x,
    output logic signed [OW-1:0] y,
    output logic                 hit
);
    localparam logic signed [IW-1:0] HI = IW'((2 ** (OW - 1)) - 1);
    localparam logic signed [IW-1:0] LO = ~HI;

    logic signed [IW-1:0] shd;

    assign shd = x >>> SH;

    always_comb begin
        if (shd > HI) begin
            y   = HI[OW-1:0];
            hit = 1'b1;
        end else if (shd < LO) begin
            y   = LO[OW-1:0];
            hit = 1'b1;
        end else begin
            y   = shd[OW-1:0];
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/bfly_core.sv
module bfly_core
    import bfly_pkg::*;
#(
    parameter int W       = 12,
    parameter int TW      = 12,
    parameter int SHIFT   = 1,
    parameter int USE_DIF = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sof,
    input  logic                 valid_in,
    input  logic signed [W-1:0]  a_re,
    input  logic signed [W-1:0]  a_im,
    input  logic signed [W-1:0]  b_re,
    input  logic signed [W-1:0]  b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 valid_out,
    output logic signed [W-1:0]  y0_re,
    output logic signed [W-1:0]  y0_im,
    output logic signed [W-1:0]  y1_re,
    output logic signed [W-1:0]  y1_im,
    output logic                 sat_flag
);
    localparam int FRAC  = TW - 1;        // twiddle fraction bits
    localparam int FW    = W + TW + 2;    // full-precision datapath width
    localparam int TOTSH = FRAC + SHIFT;  // twiddle rescale plus write-back scale
    localparam int LANES = 4;             // y0 re, y0 im, y1 re, y1 im

    logic [2:0]           vld_q;
    logic signed [FW-1:0] s2_q   [LANES];
    logic signed [W-1:0]  lane_y [LANES];
    logic signed [W-1:0]  out_q  [LANES];
    logic [LANES-1:0]     lane_hit;
    logic                 clamp_evt;
    flag_state_e          st_q, st_d;

    // Valid shift line: stage 1, stage 2, output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[1:0], valid_in};
    end

    generate
        if (USE_DIF == 0) begin : g_dit
            // Stage 1: rotate B by the twiddle first.
            logic signed [W+TW:0] t_re, t_im;
            logic signed [W+TW:0] s1_t_re, s1_t_im;
            logic signed [W-1:0]  s1_a_re, s1_a_im;
            logic signed [W+TW:0] a_sc_re, a_sc_im;
            logic signed [FW-1:0] y0r, y0i, y1r, y1i;

            bfly_cmul #(.AW(W), .BW(TW)) u_rot (
                .xr(b_re), .xi(b_im), .wr(w_re), .wi(w_im),
                .pr(t_re), .pi(t_im)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1_t_re <= '0;
                    s1_t_im <= '0;
                    s1_a_re <= '0;
                    s1_a_im <= '0;
                end else begin
                    s1_t_re <= t_re;
                    s1_t_im <= t_im;
                    s1_a_re <= a_re;
                    s1_a_im <= a_im;
                end
            end

            // Stage 2: put A on the product's fixed-point grid, then add and subtract.
            assign a_sc_re = (W+TW+1)'(s1_a_re) <<< FRAC;
            assign a_sc_im = (W+TW+1)'(s1_a_im) <<< FRAC;

            bfly_addsub #(.IW(W+TW+1)) u_as_re (
                .x(a_sc_re), .y(s1_t_re), .sum(y0r), .dif(y1r)
            );
            bfly_addsub #(.IW(W+TW+1)) u_as_im (
                .x(a_sc_im), .y(s1_t_im), .sum(y0i), .dif(y1i)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < LANES; i++) s2_q[i] <= '0;
                end else begin
                    s2_q[0] <= y0r;
                    s2_q[1] <= y0i;
                    s2_q[2] <= y1r;
                    s2_q[3] <= y1i;
                end
            end
        end else begin : g_dif
            // Stage 1: sum and difference first.
            logic signed [W:0]    s_re, s_im, d_re, d_im;
            logic signed [W:0]    s1_s_re, s1_s_im, s1_d_re, s1_d_im;
            logic signed [TW-1:0] s1_w_re, s1_w_im;
            logic signed [FW-1:0] p_re, p_im;

            bfly_addsub #(.IW(W)) u_as_re (
                .x(a_re), .y(b_re), .sum(s_re), .dif(d_re)
            );
            bfly_addsub #(.IW(W)) u_as_im (
                .x(a_im), .y(b_im), .sum(s_im), .dif(d_im)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1_s_re <= '0;
                    s1_s_im <= '0;
                    s1_d_re <= '0;
                    s1_d_im <= '0;
                    s1_w_re <= '0;
                    s1_w_im <= '0;
                end else begin
                    s1_s_re <= s_re;
                    s1_s_im <= s_im;
                    s1_d_re <= d_re;
                    s1_d_im <= d_im;
                    s1_w_re <= w_re;
                    s1_w_im <= w_im;
                end
            end

            // Stage 2: rotate the difference only; the sum is put on the same grid.
            bfly_cmul #(.AW(W+1), .BW(TW)) u_rot (
                .xr(s1_d_re), .xi(s1_d_im), .wr(s1_w_re), .wi(s1_w_im),
                .pr(p_re), .pi(p_im)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < LANES; i++) s2_q[i] <= '0;
                end else begin
                    s2_q[0] <= FW'(s1_s_re) <<< FRAC;
                    s2_q[1] <= FW'(s1_s_im) <<< FRAC;
                    s2_q[2] <= p_re;
                    s2_q[3] <= p_im;
                end
            end
        end
    endgenerate

    // Stage 3: scale and clamp every lane, then register the results.
    generate
        for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
            bfly_satshift #(.IW(FW), .OW(W), .SH(TOTSH)) u_sat (
                .x(s2_q[gi]), .y(lane_y[gi]), .hit(lane_hit[gi])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) out_q[i] <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) out_q[i] <= lane_y[i];
        end
    end

    assign clamp_evt = vld_q[1] && (|lane_hit);

    // Clamp flag state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_CLEAR;
        else        st_q <= st_d;
    end

    // Next state: a clamp has priority over a frame-start clear.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_CLEAR: if (clamp_evt)         st_d = FLAG_HELD;
            FLAG_HELD:  if (sof && !clamp_evt) st_d = FLAG_CLEAR;
        endcase
    end

    // Outputs.
    always_comb begin
        sat_flag  = (st_q == FLAG_HELD);
        valid_out = vld_q[2];
        y0_re     = out_q[0];
        y0_im     = out_q[1];
        y1_re     = out_q[2];
        y1_im     = out_q[3];
    end
endmodule

// File: rtl/bfly_core_chk.sv
module bfly_core_chk #(
    parameter int W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sof,
    input logic                valid_in,
    input logic                valid_out,
    input logic signed [W-1:0] y0_re,
    input logic signed [W-1:0] y0_im,
    input logic signed [W-1:0] y1_re,
    input logic signed [W-1:0] y1_im,
    input logic                sat_flag
);
    localparam logic signed [W-1:0] HI = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] LO = {1'b1, {(W-1){1'b0}}};

    logic [1:0] warm;
    logic       at_edge;

    // Counts edges since reset release so that no check looks back into reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm <= '0;
        else if (warm != 2'd3)   warm <= warm + 2'd1;
    end

    // True when any lane sits on a bound of the range.
    assign at_edge = (y0_re == HI) || (y0_re == LO) || (y0_im == HI) || (y0_im == LO) ||
                     (y1_re == HI) || (y1_re == LO) || (y1_im == HI) || (y1_im == LO);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (valid_out == $past(valid_in, 3)));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sof) |=> sat_flag);

    p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> (valid_out && at_edge));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (!sat_flag || (valid_out && at_edge)));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> !$rose(sat_flag));
endmodule

bind bfly_core bfly_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sof(sof), .valid_in(valid_in),
    .valid_out(valid_out), .y0_re(y0_re), .y0_im(y0_im),
    .y1_re(y1_re), .y1_im(y1_im), .sat_flag(sat_flag)
);

// File: tb/bfly_core_tb.sv
`timescale 1ns/1ps
module bfly_core_tb;
    localparam int W  = 12;
    localparam int TW = 12;
    localparam int SH = 1;
    localparam int F  = TW - 1;

    typedef struct packed {
        int y0r;
        int y0i;
        int y1r;
        int y1i;
        int due;
        bit clamp;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 1'b0;
    logic valid_in = 1'b0;
    logic signed [W-1:0]  a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [TW-1:0] w_re = '0, w_im = '0;

    logic vo_t, vo_f, sf_t, sf_f;
    logic signed [W-1:0] t0r, t0i, t1r, t1i, f0r, f0i, f1r, f1i;

    exp_t  q_e [2][$];
    string q_t [2][$];
    bit    m_flag [2];
    int    n_chk = 0, n_bad = 0, cyc = 0;
    bit    done = 1'b0, sof_q = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        sof_q <= sof;
    end

    bfly_core #(.W(W), .TW(TW), .SHIFT(SH), .USE_DIF(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .sof(sof), .valid_in(valid_in),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
        .valid_out(vo_t), .y0_re(t0r), .y0_im(t0i), .y1_re(t1r), .y1_im(t1i),
        .sat_flag(sf_t)
    );

    bfly_core #(.W(W), .TW(TW), .SHIFT(SH), .USE_DIF(1)) u_dut_dif (
        .clk(clk), .rst_n(rst_n), .sof(sof), .valid_in(valid_in),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
        .valid_out(vo_f), .y0_re(f0r), .y0_im(f0i), .y1_re(f1r), .y1_im(f1i),
        .sat_flag(sf_f)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R6 and R7 clamp bounds.
    function automatic int sat_w(longint v, inout bit c);
        longint hi = (longint'(1) <<< (W - 1)) - 1;
        longint lo = -(longint'(1) <<< (W - 1));
        if (v > hi) begin c = 1'b1; return int'(hi); end
        if (v < lo) begin c = 1'b1; return int'(lo); end
        return int'(v);
    endfunction

    // Reference arithmetic of R3 (time-decimated) and R4 (frequency-decimated).
    function automatic exp_t model(bit dif, int ar, int ai, int br, int bi, int wr, int wi);
        exp_t e;
        longint p0r, p0i, p1r, p1i, dr, di, tr, ti;
        bit c = 1'b0;
        if (!dif) begin
            tr  = longint'(br) * wr - longint'(bi) * wi;
            ti  = longint'(br) * wi + longint'(bi) * wr;
            p0r = (longint'(ar) <<< F) + tr;
            p0i = (longint'(ai) <<< F) + ti;
            p1r = (longint'(ar) <<< F) - tr;
            p1i = (longint'(ai) <<< F) - ti;
        end else begin
            dr  = longint'(ar) - br;
            di  = longint'(ai) - bi;
            p0r = (longint'(ar) + br) <<< F;
            p0i = (longint'(ai) + bi) <<< F;
            p1r = dr * wr - di * wi;
            p1i = dr * wi + di * wr;
        end
        e.y0r = sat_w(p0r >>> (F + SH), c);
        e.y0i = sat_w(p0i >>> (F + SH), c);
        e.y1r = sat_w(p1r >>> (F + SH), c);
        e.y1i = sat_w(p1i >>> (F + SH), c);
        e.clamp = c;
        e.due = 0;
        return e;
    endfunction

    // Driver: applies one input cycle and pushes the expected results.
    task automatic drive(int ar, int ai, int br, int bi, int wr, int wi,
                         string tag, bit vld = 1'b1, bit s = 1'b0);
        exp_t e;
        @(posedge clk);
        #1;
        a_re = W'(ar); a_im = W'(ai); b_re = W'(bi == bi ? br : 0); b_im = W'(bi);
        w_re = TW'(wr); w_im = TW'(wi);
        valid_in = vld;
        sof = s;
        if (vld) begin
            for (int d = 0; d < 2; d++) begin
                e = model(d[0], ar, ai, br, bi, wr, wi);
                e.due = cyc + 3;
                q_e[d].push_back(e);
                q_t[d].push_back(tag);
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            valid_in = 1'b0;
            sof = 1'b0;
        end
    endtask

    task automatic pulse_sof();
        @(posedge clk);
        #1;
        valid_in = 1'b0;
        sof = 1'b1;
    endtask

    // Monitor: pops and compares results as each DUT produces them.
    task automatic mon(int d);
        exp_t e;
        string tg;
        bit v = d ? vo_f : vo_t;
        bit fl = d ? sf_f : sf_t;
        string nm = d ? "dif" : "dit";
        if (v) begin
            if (q_e[d].size() == 0) begin
                check({"R2/R10 ", nm, " unexpected valid_out"}, 1, 0);
            end else begin
                e  = q_e[d].pop_front();
                tg = q_t[d].pop_front();
                check({"R2 ", nm, " latency ", tg}, cyc, e.due);
                check({nm, " y0_re ", tg}, int'(d ? f0r : t0r), e.y0r);
                check({nm, " y0_im ", tg}, int'(d ? f0i : t0i), e.y0i);
                check({nm, " y1_re ", tg}, int'(d ? f1r : t1r), e.y1r);
                check({nm, " y1_im ", tg}, int'(d ? f1i : t1i), e.y1i);
                if (e.clamp)    m_flag[d] = 1'b1;
                else if (sof_q) m_flag[d] = 1'b0;
            end
        end else if (sof_q) begin
            m_flag[d] = 1'b0;
        end
        if (v || sof_q) check({"R8/R9 ", nm, " sat_flag"}, int'(fl), int'(m_flag[d]));
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            mon(0);
            mon(1);
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            check("R2 watchdog run completion", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int ar, ai, br, bi, wr, wi;
        m_flag[0] = 1'b0;
        m_flag[1] = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid_out dit", int'(vo_t), 0);
        check("R1 reset valid_out dif", int'(vo_f), 0);
        check("R1 reset sat_flag", int'(sf_t | sf_f), 0);
        check("R1 reset y0_re", int'(t0r), 0);
        check("R1 reset y1_im", int'(f1i), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R3 and R4: distinct twiddles, back to back.
        drive(100, -50, 30, 70, 2047, 0, "R3/R4 unity twiddle");
        drive(500, 200, -300, 400, 0, 2047, "R3/R4 +j twiddle");
        drive(-700, 300, 250, -125, -2048, 0, "R3/R4 -1 twiddle");
        drive(321, -987, 1448, -1200, 1448, -1448, "R3/R4 diagonal twiddle");
        idle(2);

        // R5: full-scale operands, no wrap inside the datapath.
        drive(2047, 2047, 2047, 2047, 2047, 0, "R5 full-scale positive");
        drive(-2048, -2048, -2048, -2048, -2048, -2048, "R5 most negative");
        drive(2047, -2048, -2048, 2047, 0, -2048, "R5 mixed extremes");
        idle(5);
        pulse_sof();
        idle(2);

        // R6 and R7: clamping in both directions, for both forms.
        drive(2047, 0, 2047, -2047, 2047, 2047, "R6 positive clamp dit");
        drive(2047, 2047, -2048, -2048, 2047, -2047, "R6 positive clamp dif");
        drive(-2048, 0, -2048, 2047, 2047, 2047, "R7 negative clamp dit");
        drive(2047, 2047, -2048, -2048, -2048, 2047, "R7 negative clamp dif");
        idle(6);
        @(negedge clk);
        check("R8 sticky flag dit", int'(sf_t), 1);
        check("R8 sticky flag dif", int'(sf_f), 1);

        // R9: clear by frame start.
        pulse_sof();
        idle(1);
        @(negedge clk);
        check("R9 cleared dit", int'(sf_t), 0);
        check("R9 cleared dif", int'(sf_f), 0);

        // R10: out-of-range operands with valid_in low are ignored.
        drive(2047, 0, 2047, -2047, 2047, 2047, "R10 ignored", 1'b0);
        drive(-2048, 0, -2048, 2047, 2047, 2047, "R10 ignored", 1'b0);
        idle(5);
        @(negedge clk);
        check("R10 no valid_out", int'(vo_t | vo_f), 0);
        check("R10 flag untouched dit", int'(sf_t), 0);
        check("R10 flag untouched dif", int'(sf_f), 0);

        // R9: clamp registered at the same edge as sof keeps the flag set.
        drive(2047, 0, 2047, -2047, 2047, 2047, "R9 set over clear");
        idle(1);
        pulse_sof();
        idle(1);
        @(negedge clk);
        check("R9 set wins over clear dit", int'(sf_t), 1);
        pulse_sof();
        idle(3);

        // Pseudo-random stream with gaps and random frame starts (R2, R3, R4).
        for (int n = 0; n < 400; n++) begin
            ar = int'($urandom_range(4095)) - 2048;
            ai = int'($urandom_range(4095)) - 2048;
            br = int'($urandom_range(4095)) - 2048;
            bi = int'($urandom_range(4095)) - 2048;
            wr = int'($urandom_range(4095)) - 2048;
            wi = int'($urandom_range(4095)) - 2048;
            drive(ar, ai, br, bi, wr, wi, "R3/R4 random stream",
                  ($urandom_range(7) != 0), ($urandom_range(15) == 0));
        end
        idle(8);
        @(negedge clk);
        check("R2 all results returned dit", q_e[0].size(), 0);
        check("R2 all results returned dif", q_e[1].size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule